// File: doc/BRIEF.md
# Accumulator-Machine 8-Bit ALU

This block is the purely combinational arithmetic/logic unit of a small accumulator CPU. It takes two 8-bit operands, A and B, and an incoming carry. A handful of control lines then shape the operation. The adder path adds A to either B or its bitwise complement. Its carry-in comes from a four-way selector: the incoming carry, its inverse, constant 0 or constant 1.

A separate logic path computes any two-input bitwise function. The function is given as a 4-bit truth table that is indexed per bit by the operand pair. A final select picks either the adder sum or the logic output as the result. Negative and zero flags are formed from that result.

The surrounding controller owns the accumulator, the flag registers and instruction decode. It applies control words and captures the outputs in the same cycle. Subtraction A−B uses the complemented B with carry-in forced to 1. The carry-out then reads as "no borrow".

Top module: `alu8_core`

## Requirements
- R1: With arith_sel=1, add_nsub=1 and cin_sel=10 (constant 0), result equals (A+B) mod 256, and cout is bit 8 of the 9-bit sum A+B.
- R2: With add_nsub=0, the adder's second operand is the bitwise complement of B. With arith_sel=1 and cin_sel=10, result equals (A + ~B) mod 256.
- R3: cin_sel selects the adder carry-in. 00 gives carry_in, 01 gives NOT carry_in, 10 gives 0 and 11 gives 1. The result is A + Bsel + that bit.
- R4: With arith_sel=1, add_nsub=0 and cin_sel=11, result equals (A−B) mod 256, and cout=1 exactly when A ≥ B (unsigned).
- R5: For each bit i, the logic output bit equals func[{A[i],B[i]}]. This makes func=1000 AND, 1110 OR, 0110 XOR and 0011 NOT A.
- R6: arith_sel=1 drives the adder sum onto result. arith_sel=0 drives the logic output.
- R7: zero=1 exactly when all 8 result bits are 0.
- R8: neg equals bit 7 of the selected result.
- R9: cout always reports the adder's carry-out, including when arith_sel=0 selects the logic output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 8 | First operand (accumulator side) |
| b | input | 8 | Second operand (bus side) |
| carry_in | input | 1 | Incoming carry from the flag register |
| add_nsub | input | 1 | 1 passes B to the adder, 0 passes ~B |
| cin_sel | input | 2 | Adder carry-in source select |
| func | input | 4 | Logic-unit truth table |
| arith_sel | input | 1 | 1 selects the adder sum, 0 selects the logic output |
| result | output | 8 | Selected result |
| cout | output | 1 | Adder carry-out |
| neg | output | 1 | Result bit 7 |
| zero | output | 1 | Result is all zeros |

## Verification
The bench targets wrap-around sums such as FF+01. A design that drops the ninth bit there would leave cout low even though zero correctly rises. Subtraction is driven with A<B, A=B and A>B. A swapped carry selector or an inverted complement control would show up as a wrong no-borrow bit, or as an off-by-one difference.

Each logic code, plus non-standard truth tables, is applied to operands that exercise all four bit pairs. A truth table indexed as {B,A} instead of {A,B} would then make NOT A come out as NOT B. Logic mode is also run with operands whose sum overflows, to catch a cout that is gated by the result select.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        CIN_PASS = 2'b00,
        CIN_INV  = 2'b01,
        CIN_ZERO = 2'b10,
        CIN_ONE  = 2'b11
    } cin_src_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } flag_t;

    function automatic logic pick_carry(cin_src_e src, logic c);
        logic r;
        unique case (src)
            CIN_PASS: r = c;
            CIN_INV:  r = ~c;
            CIN_ZERO: r = 1'b0;
            default:  r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             add_nsub,
    input  logic [1:0]       cin_sel,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic             cin_eff;
    logic [EXT_W-1:0] total;

    always_comb begin
        b_eff   = add_nsub ? b : ~b;
        cin_eff = pick_carry(cin_src_e'(cin_sel), carry_in);
        total   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
    end

    assign sum  = total[WIDTH-1:0];
    assign cout = total[EXT_W-1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       func,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [1:0] idx;
        assign idx  = {a[i], b[i]};
        assign y[i] = func[idx];
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] res,
    output flag_t            flags
);
    assign flags.neg  = res[WIDTH-1];
    assign flags.zero = ~|res;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned WIDTH = DATA_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    input  logic             add_nsub,
    input  logic [1:0]       cin_sel,
    input  logic [3:0]       func,
    input  logic             arith_sel,
    output logic [WIDTH-1:0] result,
    output logic             cout,
    output logic             neg,
    output logic             zero
);
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH-1:0] lgc_w;
    flag_t            flg_w;

    alu8_adder #(.WIDTH(WIDTH)) u_add (
        .a        (a),
        .b        (b),
        .add_nsub (add_nsub),
        .cin_sel  (cin_sel),
        .carry_in (carry_in),
        .sum      (sum_w),
        .cout     (cout)
    );

    alu8_logic #(.WIDTH(WIDTH)) u_lgc (
        .a    (a),
        .b    (b),
        .func (func),
        .y    (lgc_w)
    );

    assign result = arith_sel ? sum_w : lgc_w;

    alu8_flags #(.WIDTH(WIDTH)) u_flg (
        .res   (result),
        .flags (flg_w)
    );

    assign neg  = flg_w.neg;
    assign zero = flg_w.zero;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             add_nsub,
    input logic [1:0]       cin_sel,
    input logic [3:0]       func,
    input logic             arith_sel,
    input logic [WIDTH-1:0] result,
    input logic             cout,
    input logic             zero
);
    logic [WIDTH:0] plain_sum;
    assign plain_sum = {1'b0, a} + {1'b0, b};

    always_comb begin
        if (arith_sel && add_nsub && cin_sel == 2'b10)
            AST_PLAIN_ADD: assert ({cout, result} == plain_sum); // R1
        if (arith_sel && !add_nsub && cin_sel == 2'b11)
            AST_NO_BORROW: assert (cout == (a >= b)); // R4
        if (arith_sel && !add_nsub && cin_sel == 2'b11 && a == b)
            AST_EQUAL_ZERO: assert (zero); // R7
        if (!arith_sel && func == 4'b0011)
            AST_INV_A: assert (result == ~a); // R5
        if (!arith_sel && func == 4'b1000)
            AST_AND_CODE: assert (result == (a & b)); // R5
        if (!arith_sel && add_nsub && cin_sel == 2'b10)
            AST_LOGIC_CARRY: assert (cout == plain_sum[WIDTH]); // R9
    end
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (
    .a         (a),
    .b         (b),
    .add_nsub  (add_nsub),
    .cin_sel   (cin_sel),
    .func      (func),
    .arith_sel (arith_sel),
    .result    (result),
    .cout      (cout),
    .zero      (zero)
);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
    logic       clk = 1'b0;
    logic [7:0] a, b;
    logic       carry_in, add_nsub, arith_sel;
    logic [1:0] cin_sel;
    logic [3:0] func;
    logic [7:0] result;
    logic       cout, neg, zero;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    alu8_core u_dut (
        .a(a), .b(b), .carry_in(carry_in), .add_nsub(add_nsub),
        .cin_sel(cin_sel), .func(func), .arith_sel(arith_sel),
        .result(result), .cout(cout), .neg(neg), .zero(zero)
    );

    function automatic logic [10:0] model(logic [7:0] xa, logic [7:0] xb,
            logic ci, logic as, logic [1:0] cs, logic [3:0] f, logic sel);
        logic [8:0] s;
        logic [7:0] bb, lg, r;
        logic       c;
        bb = as ? xb : ~xb;
        case (cs)
            2'b00: c = ci;
            2'b01: c = ~ci;
            2'b10: c = 1'b0;
            default: c = 1'b1;
        endcase
        s = {1'b0, xa} + {1'b0, bb} + {8'd0, c};
        for (int i = 0; i < 8; i++) lg[i] = f[{xa[i], xb[i]}];
        r = sel ? s[7:0] : lg;
        return {s[8], r[7], (r == 8'd0), r};
    endfunction

    task automatic drive(logic [7:0] xa, logic [7:0] xb, logic ci, logic as,
                         logic [1:0] cs, logic [3:0] f, logic sel);
        @(posedge clk);
        #2;
        a = xa; b = xb; carry_in = ci; add_nsub = as;
        cin_sel = cs; func = f; arith_sel = sel;
        #5;
    endtask

    task automatic check(string tag, logic [10:0] got, logic [10:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got cout=%b neg=%b zero=%b res=%h, exp cout=%b neg=%b zero=%b res=%h",
                     tag, got[10], got[9], got[8], got[7:0], exp[10], exp[9], exp[8], exp[7:0]);
        end
    endtask

    task automatic vec(string tag, logic [7:0] xa, logic [7:0] xb, logic ci,
                       logic as, logic [1:0] cs, logic [3:0] f, logic sel);
        drive(xa, xb, ci, as, cs, f, sel);
        check(tag, {cout, neg, zero, result}, model(xa, xb, ci, as, cs, f, sel));
    endtask

    task automatic t_idle();
        drive(8'h00, 8'h00, 1'b0, 1'b0, 2'b00, 4'b0000, 1'b0);
        check("R7 idle zero", {cout, neg, zero, result}, {1'b0, 1'b0, 1'b1, 8'h00});
    endtask

    task automatic t_add();
        drive(8'h12, 8'h34, 1'b1, 1'b1, 2'b10, 4'b0000, 1'b1);
        check("R1 add 12+34", {cout, result}, {2'b0, 8'h46} & 11'h1FF);
        drive(8'hFF, 8'h01, 1'b0, 1'b1, 2'b10, 4'b0000, 1'b1);
        check("R1 add FF+01 wrap", {cout, neg, zero, result}, {1'b1, 1'b0, 1'b1, 8'h00});
        vec("R1 add 80+80", 8'h80, 8'h80, 1'b0, 1'b1, 2'b10, 4'b0000, 1'b1);
    endtask

    task automatic t_inv_b();
        drive(8'h10, 8'h0F, 1'b0, 1'b0, 2'b10, 4'b0000, 1'b1);
        check("R2 A+~B", {cout, result}, {3'b000, 8'h00} | {2'b0, 1'b1, 8'h00});
        vec("R2 A+~B 55,AA", 8'h55, 8'hAA, 1'b1, 1'b0, 2'b10, 4'b0000, 1'b1);
    endtask

    task automatic t_cin();
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
                vec("R3 carry select", 8'h7F, 8'h00, c[0], 1'b1, s[1:0], 4'b0000, 1'b1);
            end
        end
        drive(8'hFF, 8'h00, 1'b0, 1'b1, 2'b01, 4'b0000, 1'b1);
        check("R3 inverted carry FF", {cout, zero, result}, {1'b1, 1'b1, 8'h00} | 11'h000);
    endtask

    task automatic t_sub();
        drive(8'h30, 8'h10, 1'b0, 1'b0, 2'b11, 4'b0000, 1'b1);
        check("R4 sub A>B", {cout, result}, {1'b1, 8'h20} | 11'h000);
        drive(8'h42, 8'h42, 1'b0, 1'b0, 2'b11, 4'b0000, 1'b1);
        check("R4 sub A=B", {cout, zero, result}, {1'b1, 1'b1, 8'h00} | 11'h000);
        drive(8'h05, 8'h06, 1'b0, 1'b0, 2'b11, 4'b0000, 1'b1);
        check("R4 sub A<B borrow", {cout, neg, result}, {1'b0, 1'b1, 8'hFF} | 11'h000);
    endtask

    task automatic t_logic();
        drive(8'hCC, 8'hAA, 1'b0, 1'b1, 2'b00, 4'b1000, 1'b0);
        check("R5 AND", {3'b0, result}, {3'b0, 8'h88});
        drive(8'hCC, 8'hAA, 1'b0, 1'b1, 2'b00, 4'b1110, 1'b0);
        check("R5 OR", {3'b0, result}, {3'b0, 8'hEE});
        drive(8'hCC, 8'hAA, 1'b0, 1'b1, 2'b00, 4'b0110, 1'b0);
        check("R5 XOR", {3'b0, result}, {3'b0, 8'h66});
        drive(8'hCC, 8'hAA, 1'b0, 1'b1, 2'b00, 4'b0011, 1'b0);
        check("R5 INV gives NOT A", {3'b0, result}, {3'b0, 8'h33});
        for (int f = 0; f < 16; f++)
            vec("R5 truth table", 8'hCC, 8'hAA, 1'b0, 1'b1, 2'b10, f[3:0], 1'b0);
    endtask

    task automatic t_select();
        drive(8'h0F, 8'hF0, 1'b0, 1'b1, 2'b10, 4'b1000, 1'b1);
        check("R6 sel arith", {3'b0, result}, {3'b0, 8'hFF});
        drive(8'h0F, 8'hF0, 1'b0, 1'b1, 2'b10, 4'b1000, 1'b0);
        check("R6 sel logic", {3'b0, result}, {3'b0, 8'h00});
    endtask

    task automatic t_flags();
        drive(8'h80, 8'h00, 1'b0, 1'b1, 2'b00, 4'b1110, 1'b0);
        check("R8 neg from bit7", {9'b0, neg, zero}, {9'b0, 1'b1, 1'b0});
        drive(8'h7F, 8'h00, 1'b0, 1'b1, 2'b00, 4'b1110, 1'b0);
        check("R8 neg clear", {9'b0, neg, zero}, {9'b0, 1'b0, 1'b0});
        drive(8'h01, 8'h00, 1'b0, 1'b1, 2'b00, 4'b1110, 1'b0);
        check("R7 zero clear nonzero", {10'b0, zero}, {10'b0, 1'b0});
    endtask

    task automatic t_logic_carry();
        drive(8'hF0, 8'h20, 1'b0, 1'b1, 2'b10, 4'b1000, 1'b0);
        check("R9 cout in logic mode", {cout, result}, {1'b1, 8'h20} | 11'h000);
        drive(8'h10, 8'h20, 1'b1, 1'b1, 2'b00, 4'b0110, 1'b0);
        check("R9 no cout in logic mode", {cout, result}, {1'b0, 8'h30} | 11'h000);
        vec("R9 logic with sub carry", 8'h05, 8'h06, 1'b0, 1'b0, 2'b11, 4'b1110, 1'b0);
    endtask

    initial begin
        a = '0; b = '0; carry_in = 0; add_nsub = 0; cin_sel = '0; func = '0; arith_sel = 0;
        t_idle();
        t_add();
        t_inv_b();
        t_cin();
        t_sub();
        t_logic();
        t_select();
        t_flags();
        t_logic_carry();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles, exp at most 5000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule